// File: doc/BRIEF.md
# Bus-Programmed Wiper Position Controller

This block is the digital front end of a digitally controlled resistor ladder. It watches the two open-drain lines of an I2C bus and acts as a write-addressed slave. Inside it are a 10-bit wiper register and four 10-bit stored value registers. The wiper register is decoded into a one-hot tap-select vector. Exactly one of the 1024 ladder switches is closed at any time. Tap 0 is the low end of the ladder and tap 1023 is the high end.

A transaction opens with a start condition and an address byte, and a command byte follows. Each command byte holds a 4-bit opcode in bits [7:4], a register index in bits [3:2] and the two upper value bits in bits [1:0]. A write command takes one more data byte with the lower eight value bits. A read command makes the slave transmit right after the command acknowledge. No data stream runs through the block, so there is no valid/ready pair at its edge. Back-pressure is the bus itself: the master sets the pace with SCL, and the block never stretches the clock. All pins are plain control pins.

Top module: `wiper_i2c_ctrl`

## Requirements
- R1: The block leaves SDA alone and changes no register until it has seen a start condition, which is SDA falling while SCL is high. A start seen in the middle of a transaction restarts address reception.
- R2: A stop condition is SDA rising while SCL is high. It ends any transaction at once and releases SDA. An unfinished write does not change any register.
- R3: The address byte is acknowledged only when it equals {SLAVE_ADDR, 1'b0}, with the address in the upper seven bits and bit 0 equal to 0. Any other address gets no acknowledge, and every byte after it is ignored until the next start.
- R4: The command byte is acknowledged only for opcodes 0x1 to 0x5 in bits [7:4]. Any other opcode gets no acknowledge and ends the transaction. Acknowledge means SDA is held low for the whole of the ninth SCL high phase.
- R5: Opcode 0x1 writes the wiper register with {cmd[1:0], data[7:0]}. The write takes effect only when the SCL low phase that ends the data acknowledge begins, and the tap output does not change before then.
- R6: Opcode 0x2 writes stored register cmd[3:2] with {cmd[1:0], data[7:0]}. The wiper and the other stored registers do not change.
- R7: Opcode 0x3 copies stored register cmd[3:2] into the wiper register when the command acknowledge ends. No data byte is taken.
- R8: Opcode 0x4 reads the wiper register. The first byte sent, MSB first, is value[7:0]. Each master acknowledge makes the slave send the other half next: {6'b0, value[9:8]}, then value[7:0] again, and so on. A master non-acknowledge releases SDA for the rest of the transaction.
- R9: Opcode 0x5 reads stored register cmd[3:2] with the same byte order as R8.
- R10: tap_sel has exactly one bit set, and that bit is at the index equal to the wiper value.
- R11: After reset the wiper and all four stored registers hold 0x200, so tap_sel[512] is the active tap.
- R12: Once a write has been acknowledged, further data bytes in the same transaction are not acknowledged and have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low (open-drain) |
| tap_sel | output | 1024 | One-hot ladder switch select, index = wiper value |

## Verification
The main same-cycle collision is a bus condition landing on the very edge where the slave would drive SDA or commit a write. One case is a stop right after four bits of a data byte. Another is a repeated start halfway through a command. In both the bench checks that the pending write is dropped and that SDA is free afterwards. The other collision is the register commit against the tap decode. Sweeps over wiper values and copies from stored registers check that tap_sel never moves before the acknowledge ends and always moves to the expected index once it does.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_CMD,
    ST_CACK,
    ST_DATA,
    ST_DACK,
    ST_TX,
    ST_MACK,
    ST_DONE
  } bus_st_t;

  localparam logic [3:0] OP_WR_WIPER = 4'h1;
  localparam logic [3:0] OP_WR_STORE = 4'h2;
  localparam logic [3:0] OP_COPY     = 4'h3;
  localparam logic [3:0] OP_RD_WIPER = 4'h4;
  localparam logic [3:0] OP_RD_STORE = 4'h5;

  typedef struct packed {
    logic       wr_wiper;
    logic       wr_store;
    logic       copy_store;
    logic [1:0] idx;
  } reg_cmd_t;

  function automatic logic op_valid(input logic [3:0] op);
    return (op >= OP_WR_WIPER) && (op <= OP_RD_STORE);
  endfunction

endpackage

// File: rtl/wpr_bus_sync.sv
module wpr_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_p, sda_p;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/wpr_bus_fsm.sv
module wpr_bus_fsm
  import wpr_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h2C,
  parameter int         VAL_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [VAL_W-1:0] rd_val,
  output logic             rd_store,
  output logic [1:0]       rd_idx,
  output reg_cmd_t         wr_cmd,
  output logic [VAL_W-1:0] wr_val,
  output logic             sda_oe
);
  localparam int HI_W = VAL_W - 8;

  bus_st_t    st_q;
  logic [3:0] cnt_q;
  logic [7:0] rx_q;
  logic [7:0] cmd_q;
  logic [7:0] tx_q;
  logic       hi_next_q;
  logic       mack_q;
  logic       oe_q;
  reg_cmd_t   wr_q;
  logic [VAL_W-1:0] wv_q;

  logic [7:0] lo_byte, hi_byte, next_byte;
  logic       byte_in;

  assign lo_byte   = rd_val[7:0];
  assign hi_byte   = {{(8-HI_W){1'b0}}, rd_val[VAL_W-1:8]};
  assign next_byte = hi_next_q ? hi_byte : lo_byte;
  assign byte_in   = scl_fall && (cnt_q == 4'd8);

  assign rd_store = (cmd_q[7:4] == OP_RD_STORE);
  assign rd_idx   = cmd_q[3:2];
  assign wr_cmd   = wr_q;
  assign wr_val   = wv_q;
  assign sda_oe   = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      rx_q      <= '0;
      cmd_q     <= '0;
      tx_q      <= '0;
      hi_next_q <= 1'b0;
      mack_q    <= 1'b0;
      oe_q      <= 1'b0;
      wr_q      <= '0;
      wv_q      <= '0;
    end else begin
      wr_q <= '0;
      if (stop_det) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else if (start_det) begin
        st_q  <= ST_ADDR;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_CMD, ST_DATA: begin
            if (scl_rise && cnt_q < 4'd8) begin
              rx_q  <= {rx_q[6:0], sda_s};
              cnt_q <= cnt_q + 4'd1;
            end else if (byte_in) begin
              if (st_q == ST_ADDR) begin
                if (rx_q == {SLAVE_ADDR, 1'b0}) begin
                  oe_q <= 1'b1;
                  st_q <= ST_AACK;
                end else begin
                  st_q <= ST_DONE;
                end
              end else if (st_q == ST_CMD) begin
                if (op_valid(rx_q[7:4])) begin
                  cmd_q <= rx_q;
                  oe_q  <= 1'b1;
                  st_q  <= ST_CACK;
                end else begin
                  st_q <= ST_DONE;
                end
              end else begin
                oe_q <= 1'b1;
                st_q <= ST_DACK;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              oe_q  <= 1'b0;
              cnt_q <= '0;
              st_q  <= ST_CMD;
            end
          end
          ST_CACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              unique case (cmd_q[7:4])
                OP_WR_WIPER, OP_WR_STORE: begin
                  oe_q <= 1'b0;
                  st_q <= ST_DATA;
                end
                OP_COPY: begin
                  oe_q            <= 1'b0;
                  wr_q.copy_store <= 1'b1;
                  wr_q.idx        <= cmd_q[3:2];
                  st_q            <= ST_DONE;
                end
                default: begin
                  tx_q      <= lo_byte;
                  oe_q      <= ~lo_byte[7];
                  hi_next_q <= 1'b1;
                  st_q      <= ST_TX;
                end
              endcase
            end
          end
          ST_DACK: begin
            if (scl_fall) begin
              oe_q          <= 1'b0;
              wr_q.wr_wiper <= (cmd_q[7:4] == OP_WR_WIPER);
              wr_q.wr_store <= (cmd_q[7:4] == OP_WR_STORE);
              wr_q.idx      <= cmd_q[3:2];
              wv_q          <= {cmd_q[HI_W-1:0], rx_q};
              st_q          <= ST_DONE;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                oe_q <= 1'b0;
                st_q <= ST_MACK;
              end else begin
                tx_q <= {tx_q[6:0], 1'b0};
                oe_q <= ~tx_q[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                tx_q      <= next_byte;
                oe_q      <= ~next_byte[7];
                hi_next_q <= ~hi_next_q;
                cnt_q     <= '0;
                st_q      <= ST_TX;
              end else begin
                st_q <= ST_DONE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/wpr_regs.sv
module wpr_regs
  import wpr_pkg::*;
#(
  parameter int               VAL_W     = 10,
  parameter int               NREG      = 4,
  parameter logic [VAL_W-1:0] RESET_VAL = 10'h200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  reg_cmd_t         wr_cmd,
  input  logic [VAL_W-1:0] wr_val,
  input  logic             rd_store,
  input  logic [1:0]       rd_idx,
  output logic [VAL_W-1:0] rd_val,
  output logic [VAL_W-1:0] wiper
);
  logic [VAL_W-1:0] store_q [NREG];
  logic [VAL_W-1:0] wiper_q;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          store_q[g] <= RESET_VAL;
        end else if (wr_cmd.wr_store && wr_cmd.idx == 2'(g)) begin
          store_q[g] <= wr_val;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper_q <= RESET_VAL;
    end else if (wr_cmd.wr_wiper) begin
      wiper_q <= wr_val;
    end else if (wr_cmd.copy_store) begin
      wiper_q <= store_q[wr_cmd.idx];
    end
  end

  assign rd_val = rd_store ? store_q[rd_idx] : wiper_q;
  assign wiper  = wiper_q;

endmodule

// File: rtl/wpr_tap_decode.sv
module wpr_tap_decode #(
  parameter int VAL_W = 10,
  localparam int TAPS = 1 << VAL_W
) (
  input  logic [VAL_W-1:0] wiper,
  output logic [TAPS-1:0]  tap_sel
);
  generate
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
      assign tap_sel[i] = (wiper == VAL_W'(i));
    end
  endgenerate
endmodule

// File: rtl/wiper_i2c_ctrl.sv
module wiper_i2c_ctrl
  import wpr_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h2C,
  parameter int         VAL_W       = 10,
  parameter int         NREG        = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [VAL_W-1:0] RESET_VAL = 10'h200
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe,
  output logic [(1<<VAL_W)-1:0]   tap_sel
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             rd_store;
  logic [1:0]       rd_idx;
  logic [VAL_W-1:0] rd_val, wr_val, wiper;
  reg_cmd_t         wr_cmd;

  wpr_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  wpr_bus_fsm #(.SLAVE_ADDR(SLAVE_ADDR), .VAL_W(VAL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_val(rd_val), .rd_store(rd_store), .rd_idx(rd_idx),
    .wr_cmd(wr_cmd), .wr_val(wr_val), .sda_oe(sda_oe)
  );

  wpr_regs #(.VAL_W(VAL_W), .NREG(NREG), .RESET_VAL(RESET_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_val(wr_val),
    .rd_store(rd_store), .rd_idx(rd_idx), .rd_val(rd_val), .wiper(wiper)
  );

  wpr_tap_decode #(.VAL_W(VAL_W)) u_dec (
    .wiper(wiper), .tap_sel(tap_sel)
  );

endmodule

// File: rtl/wiper_i2c_ctrl_chk.sv
module wiper_i2c_ctrl_chk #(
  parameter int VAL_W = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  scl_fall,
  input logic                  start_det,
  input logic                  stop_det,
  input logic                  wr_any,
  input logic                  sda_oe,
  input logic [(1<<VAL_W)-1:0] tap_sel
);
  // R10: exactly one tap closed
  a_r10_one_tap: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);

  // R2: a stop leaves SDA released on the next cycle
  a_r2_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R5: the tap moves only after a register write strobe
  a_r5_tap_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tap_sel) |-> $past(wr_any));

  // R4: the slave starts pulling SDA only just after an SCL fall
  a_r4_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R4: outside bus conditions, SDA drive changes only while SCL is low
  a_r4_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(stop_det) && !$past(start_det)) |-> !scl_s);
endmodule

bind wiper_i2c_ctrl wiper_i2c_ctrl_chk #(.VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det),
  .wr_any(wr_cmd.wr_wiper | wr_cmd.copy_store),
  .sda_oe(sda_oe), .tap_sel(tap_sel)
);

// File: tb/wiper_i2c_ctrl_tb.sv
module wiper_i2c_ctrl_tb;
  localparam logic [6:0] ADDR = 7'h2C;
  localparam int Q = 6;
  localparam int H = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [1023:0] tap_sel;
  wire  sda_line = sda_m & ~sda_oe;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int wiper_m;
  int store_m [4];

  always #10 clk = ~clk;

  wiper_i2c_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .tap_sel(tap_sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_tap(input string req, input int exp);
    int cnt = 0;
    int idx = -1;
    for (int i = 0; i < 1024; i++) if (tap_sel[i]) begin cnt++; idx = i; end
    chk(cnt == 1 && idx == exp, req, (cnt == 1) ? idx : -cnt, exp);
  endtask

  task automatic bstart();
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(H);
    sda_m = 1'b0; wclk(H);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b1; wclk(H);
    sda_m = 1'b1; wclk(H);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wclk(Q);
    scl_m = 1'b1; wclk(H);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(H/2);
    ack = !sda_line; wclk(H/2);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic recv(output logic [7:0] b, input logic mack);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wclk(Q);
      scl_m = 1'b1; wclk(H/2);
      b = {b[6:0], sda_line}; wclk(H/2);
      scl_m = 1'b0;
    end
    wclk(1);
    sda_m = mack ? 1'b0 : 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(H);
    scl_m = 1'b0; wclk(Q);
    sda_m = 1'b1;
  endtask

  task automatic write_txn(input logic [3:0] op, input int idx, input int val,
                           output logic a0, output logic a1, output logic a2);
    bstart();
    send({ADDR, 1'b0}, a0);
    send({op, 2'(idx), 2'(val >> 8)}, a1);
    send(8'(val), a2);
    bstop();
  endtask

  task automatic read_txn(input logic [3:0] op, input int idx, output int val,
                          output logic ok);
    logic a0, a1;
    logic [7:0] lo, hi;
    bstart();
    send({ADDR, 1'b0}, a0);
    send({op, 2'(idx), 2'b00}, a1);
    recv(lo, 1'b1);
    recv(hi, 1'b0);
    bstop();
    val = {hi[1:0], lo};
    ok = a0 && a1 && (hi[7:2] == 6'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2;
    int v, rv;
    logic ok;
    logic [7:0] b0, b1, b2;

    wiper_m = 'h200;
    for (int i = 0; i < 4; i++) store_m[i] = 'h200;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);

    // R11: reset state
    chk_tap("R11 reset tap", 'h200);
    chk(sda_oe == 1'b0, "R11 reset sda", sda_oe, 0);
    for (int i = 0; i < 4; i++) begin
      read_txn(4'h5, i, rv, ok);
      chk(ok && rv == 'h200, "R11/R9 reset store", rv, 'h200);
    end

    // R1: no start -> nothing acknowledged, nothing written
    scl_m = 1'b0; wclk(Q);
    send({ADDR, 1'b0}, a0);
    send(8'h13, a1);
    send(8'h21, a2);
    chk(!a0 && !a1 && !a2, "R1 no ack without start", {a0, a1, a2}, 0);
    scl_m = 1'b1; wclk(H);
    chk_tap("R1 tap untouched", wiper_m);

    // R3: address sweep
    for (int a = 0; a < 128; a++) begin
      bstart();
      send({7'(a), 1'b0}, a0);
      bstop();
      chk(a0 == (a == ADDR), "R3 address match", a0, (a == ADDR));
    end
    bstart(); send({ADDR, 1'b1}, a0); bstop();
    chk(!a0, "R3 read bit not matched", a0, 0);
    bstart();
    send({7'(ADDR ^ 7'h01), 1'b0}, a0);
    send(8'h13, a1);
    send(8'h77, a2);
    bstop();
    chk(!a0 && !a1 && !a2, "R3 mismatch ignores rest", {a0, a1, a2}, 0);
    chk_tap("R3 tap untouched", wiper_m);

    // R4: opcode sweep (index 0)
    for (int op = 0; op < 16; op++) begin
      bstart();
      send({ADDR, 1'b0}, a0);
      send({4'(op), 4'b0000}, a1);
      if (a1 && (op == 4 || op == 5)) recv(b0, 1'b0);
      bstop();
      chk(a1 == (op >= 1 && op <= 5), "R4 opcode ack", a1, (op >= 1 && op <= 5));
      if (op == 3) wiper_m = store_m[0];
    end
    chk_tap("R4 tap after sweep", wiper_m);

    // R5: wiper write sweep, tap unchanged until data ack
    for (int k = 0; k < 50; k++) begin
      v = (k == 0) ? 0 : (k == 1) ? 1023 : (k * 83 + 5) % 1024;
      bstart();
      send({ADDR, 1'b0}, a0);
      send({4'h1, 2'b00, 2'(v >> 8)}, a1);
      chk_tap("R5 no early write", wiper_m);
      send(8'(v), a2);
      wclk(2);
      chk(a0 && a1 && a2, "R5 write acks", {a0, a1, a2}, 7);
      wiper_m = v;
      chk_tap("R5/R10 tap after write", wiper_m);
      bstop();
    end

    // R6 + R9: stored registers
    for (int i = 0; i < 4; i++) begin
      v = 'h0C3 + i * 'h105;
      write_txn(4'h2, i, v, a0, a1, a2);
      store_m[i] = v;
      chk(a0 && a1 && a2, "R6 store acks", {a0, a1, a2}, 7);
      chk_tap("R6 wiper untouched", wiper_m);
    end
    for (int i = 0; i < 4; i++) begin
      read_txn(4'h5, i, rv, ok);
      chk(ok && rv == store_m[i], "R9 store readback", rv, store_m[i]);
    end

    // R7: copy each stored register
    for (int i = 3; i >= 0; i--) begin
      bstart();
      send({ADDR, 1'b0}, a0);
      send({4'h3, 2'(i), 2'b00}, a1);
      bstop();
      wiper_m = store_m[i];
      chk_tap("R7 copy", wiper_m);
    end

    // R8: read wiper, alternating halves, NACK releases
    bstart();
    send({ADDR, 1'b0}, a0);
    send({4'h4, 4'b0000}, a1);
    recv(b0, 1'b1);
    recv(b1, 1'b1);
    recv(b2, 1'b0);
    chk(b0 == 8'(wiper_m), "R8 low byte", b0, 8'(wiper_m));
    chk(b1 == 8'(wiper_m >> 8), "R8 high byte", b1, 8'(wiper_m >> 8));
    chk(b2 == 8'(wiper_m), "R8 low byte again", b2, 8'(wiper_m));
    chk(sda_oe == 1'b0, "R8 release after nack", sda_oe, 0);
    bstop();

    // R12: extra data byte ignored
    bstart();
    send({ADDR, 1'b0}, a0);
    send({4'h1, 2'b00, 2'b10}, a1);
    send(8'h5A, a2);
    wiper_m = 'h25A;
    send(8'hFF, b0[0]);
    bstop();
    chk(a2 && !b0[0], "R12 extra byte not acked", b0[0], 0);
    chk_tap("R12 extra byte no effect", wiper_m);

    // R2: stop inside data byte
    bstart();
    send({ADDR, 1'b0}, a0);
    send({4'h1, 2'b00, 2'b01}, a1);
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
    bstop();
    chk_tap("R2 stop aborts write", wiper_m);
    chk(sda_oe == 1'b0, "R2 sda released", sda_oe, 0);
    // R2: stop right after command acknowledge
    bstart();
    send({ADDR, 1'b0}, a0);
    send({4'h1, 2'b00, 2'b11}, a1);
    bstop();
    chk_tap("R2 stop before data", wiper_m);

    // R1: repeated start restarts address phase
    bstart();
    send({ADDR, 1'b0}, a0);
    send({4'h1, 2'b00, 2'b00}, a1);
    bstart();
    send({ADDR, 1'b0}, a0);
    send({4'h1, 2'b00, 2'b01}, a1);
    send(8'h23, a2);
    bstop();
    wiper_m = 'h123;
    chk(a0 && a1 && a2, "R1 repeated start acks", {a0, a1, a2}, 7);
    chk_tap("R1 repeated start write", wiper_m);
    read_txn(4'h4, 0, rv, ok);
    chk(ok && rv == wiper_m, "R8 wiper readback", rv, wiper_m);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule